// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block runs next to the frame transmit sequencer of a half-duplex Ethernet transmitter and takes charge whenever the medium reports a collision. It overrides the transmit data with a run of all-ones jam bits. If the collision is seen while preamble is still going out, the jam waits until the preamble has finished. It then decides whether the frame may be tried again. That decision rests on how far into the frame the collision happened, counted in bit times from the start of the frame.

A collision early enough starts a random wait of a whole number of slot times. The wait uses truncated binary exponential backoff, drawn from a free-running LFSR. A single-cycle pulse marks the end of the wait, and the sequencer then runs its inter-packet gap before the retry. A collision past the limit closes the frame with a late-collision flag. Too many consecutive collisions abandon the frame with an excessive-retry abort. The sequencer signals a clean transmission so that the attempt count starts again.

Top module: `coll_jam_retry`

## Requirements
- R1: A collision accepted outside preamble makes `jam_active` rise on the next clock and stay high for exactly JAM_BITS (32) cycles in which `bit_en` is high, with `jam_bit` at 1 throughout.
- R2: A collision accepted while `phase_preamble` is 1 keeps `jam_active` low for as long as `phase_preamble` stays 1. The 32-bit jam starts on the clock after `phase_preamble` is seen at 0.
- R3: A collision whose captured `bit_cnt` is below LATE_LIMIT (512) raises `retry_req` on the clock after the jam ends and holds it through the backoff wait.
- R4: For the n-th consecutive early collision, `retry_req` stays high for k*SLOT_BITS+1 cycles when `bit_en` is held at 1, where k is a whole number from 0 to 2^min(n,10)-1.
- R5: A collision whose captured `bit_cnt` is LATE_LIMIT or more gives a one-cycle `late_coll` pulse on the clock after the jam ends, with no `retry_req`.
- R6: The 16th consecutive early collision gives a one-cycle `abort_excess` pulse instead of a backoff. The attempt count then restarts, so the next collision is treated as attempt 1.
- R7: A pulse on `tx_ok` while the block is idle clears the attempt count.
- R8: `backoff_done` is high for exactly one cycle, in the last cycle of `retry_req`. `backoff_done`, `late_coll` and `abort_excess` are never high together.
- R9: `coll` has no effect while `tx_active` is 0.
- R10: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per transmitted bit time |
| tx_active | input | 1 | A frame is being transmitted |
| phase_preamble | input | 1 | The transmitter is still sending preamble |
| bit_cnt | input | CNT_W | Bit times since the start of the frame |
| coll | input | 1 | Collision detected on the medium |
| tx_ok | input | 1 | The frame finished without collision |
| jam_active | output | 1 | The jam overrides the transmit data |
| jam_bit | output | 1 | Jam data bit |
| retry_req | output | 1 | Backoff wait in progress; a retry will follow |
| backoff_done | output | 1 | One-cycle pulse when the backoff wait expires |
| abort_excess | output | 1 | One-cycle pulse: frame dropped after too many attempts |
| late_coll | output | 1 | One-cycle pulse: late collision, frame closed |

## Verification
The main function is tried with collisions at bit counts on both sides of the 511/512 boundary, with collisions during preamble of several lengths, and with a gated bit strobe. These patterns separate the early and late paths, show whether the jam is held back during preamble, and show whether the jam length is counted in bit times rather than in clocks. Runs of up to sixteen consecutive collisions check that the backoff range grows and then caps at 2^10-1. They also check that the abort comes on the sixteenth collision, and that a clean-transmit pulse in the middle of a run restarts that count.

// File: rtl/coll_pkg.sv
package coll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PRE = 2'd1,
    ST_JAM      = 2'd2,
    ST_BACKOFF  = 2'd3
  } coll_state_e;
endpackage

// File: rtl/coll_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
module coll_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q >> 1;
    if (q[0]) d = d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= d;
  end

  assign value = q;
endmodule

// File: rtl/coll_slot_timer.sv
// Counts down a number of slots, each SLOT_BITS bit times long.
module coll_slot_timer #(
  parameter int SLOT_BITS = 512,
  parameter int SLOTS_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               load,
  input  logic [SLOTS_W-1:0] slots_in,
  output logic               expired
);
  localparam int BIT_W = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic [SLOTS_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]   bit_q, bit_d;

  assign expired = (slot_q == '0);

  always_comb begin
    slot_d = slot_q;
    bit_d  = bit_q;
    if (load) begin
      slot_d = slots_in;
      bit_d  = '0;
    end else if (!expired && bit_en) begin
      if (bit_q == BIT_LAST) begin
        bit_d  = '0;
        slot_d = slot_q - 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end
endmodule

// File: rtl/coll_jam_retry.sv
module coll_jam_retry
  import coll_pkg::*;
#(
  parameter int          JAM_BITS     = 32,
  parameter int          SLOT_BITS    = 512,
  parameter int          LATE_LIMIT   = 512,
  parameter int          MAX_ATTEMPTS = 16,
  parameter int          BACKOFF_CAP  = 10,
  parameter int          CNT_W        = 16,
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS    = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             tx_active,
  input  logic             phase_preamble,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             coll,
  input  logic             tx_ok,
  output logic             jam_active,
  output logic             jam_bit,
  output logic             retry_req,
  output logic             backoff_done,
  output logic             abort_excess,
  output logic             late_coll
);
  localparam int JAM_W   = $clog2(JAM_BITS + 1);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int SLOTS_W = BACKOFF_CAP;

  coll_state_e         state_q, state_d;
  logic [JAM_W-1:0]    jam_cnt_q, jam_cnt_d;
  logic [ATT_W-1:0]    att_q, att_d, att_next;
  logic                late_q, late_d;
  logic                late_pulse_q, late_pulse_d;
  logic                abort_pulse_q, abort_pulse_d;
  logic                tmr_load, tmr_expired;
  logic [SLOTS_W-1:0]  slot_mask, slots_draw;
  logic [LFSR_W-1:0]   rnd;
  int                  exp_n;

  coll_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_W'(LFSR_SEED)),
    .TAPS (LFSR_W'(LFSR_TAPS))
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  // Truncated exponent and the mask that bounds the slot draw.
  assign att_next = att_q + 1'b1;
  always_comb begin
    exp_n = (int'(att_next) > BACKOFF_CAP) ? BACKOFF_CAP : int'(att_next);
    for (int i = 0; i < SLOTS_W; i++) slot_mask[i] = (i < exp_n);
  end
  assign slots_draw = rnd[SLOTS_W-1:0] & slot_mask;

  coll_slot_timer #(
    .SLOT_BITS (SLOT_BITS),
    .SLOTS_W   (SLOTS_W)
  ) u_slot_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .load     (tmr_load),
    .slots_in (slots_draw),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d       = state_q;
    jam_cnt_d     = jam_cnt_q;
    att_d         = att_q;
    late_d        = late_q;
    late_pulse_d  = 1'b0;
    abort_pulse_d = 1'b0;
    tmr_load      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_ok) att_d = '0;
        if (coll && tx_active) begin
          late_d    = (bit_cnt >= CNT_W'(LATE_LIMIT));
          jam_cnt_d = '0;
          state_d   = phase_preamble ? ST_WAIT_PRE : ST_JAM;
        end
      end
      ST_WAIT_PRE: begin
        if (!phase_preamble) state_d = ST_JAM;
      end
      ST_JAM: begin
        if (bit_en) begin
          if (jam_cnt_q == JAM_W'(JAM_BITS - 1)) begin
            if (late_q) begin
              late_pulse_d = 1'b1;
              att_d        = '0;
              state_d      = ST_IDLE;
            end else if (att_q == ATT_W'(MAX_ATTEMPTS - 1)) begin
              abort_pulse_d = 1'b1;
              att_d         = '0;
              state_d       = ST_IDLE;
            end else begin
              att_d    = att_next;
              tmr_load = 1'b1;
              state_d  = ST_BACKOFF;
            end
          end else begin
            jam_cnt_d = jam_cnt_q + 1'b1;
          end
        end
      end
      ST_BACKOFF: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      jam_cnt_q     <= '0;
      att_q         <= '0;
      late_q        <= 1'b0;
      late_pulse_q  <= 1'b0;
      abort_pulse_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      jam_cnt_q     <= jam_cnt_d;
      att_q         <= att_d;
      late_q        <= late_d;
      late_pulse_q  <= late_pulse_d;
      abort_pulse_q <= abort_pulse_d;
    end
  end

  assign jam_active   = (state_q == ST_JAM);
  assign jam_bit      = jam_active;
  assign retry_req    = (state_q == ST_BACKOFF);
  assign backoff_done = (state_q == ST_BACKOFF) && tmr_expired;
  assign late_coll    = late_pulse_q;
  assign abort_excess = abort_pulse_q;
endmodule

// File: rtl/coll_jam_retry_chk.sv
module coll_jam_retry_chk #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic phase_preamble,
  input logic jam_active,
  input logic retry_req,
  input logic backoff_done,
  input logic abort_excess,
  input logic late_coll
);
  localparam int JC_W = $clog2(JAM_BITS + 1) + 1;
  logic [JC_W-1:0] jcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          jcnt <= '0;
    else if (!jam_active) jcnt <= '0;
    else if (bit_en)      jcnt <= jcnt + 1'b1;
  end

  a_r1_jam_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_active) |-> (jcnt == JC_W'(JAM_BITS)));

  a_r2_after_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> !$past(phase_preamble));

  a_r3_jam_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_active) |-> (retry_req || late_coll || abort_excess));

  a_r5_late_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    late_coll |=> !retry_req);

  a_r6_abort_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    abort_excess |=> !retry_req);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |=> !backoff_done);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({backoff_done, late_coll, abort_excess}));
endmodule

bind coll_jam_retry coll_jam_retry_chk #(.JAM_BITS(JAM_BITS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bit_en         (bit_en),
  .phase_preamble (phase_preamble),
  .jam_active     (jam_active),
  .retry_req      (retry_req),
  .backoff_done   (backoff_done),
  .abort_excess   (abort_excess),
  .late_coll      (late_coll)
);

// File: tb/test_coll_jam_retry.sv
module test_coll_jam_retry;
  localparam int S = 4;
  localparam int J = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, tx_active, phase_preamble, coll, tx_ok;
  logic [15:0] bit_cnt;
  logic        jam_active, jam_bit, retry_req, backoff_done, abort_excess, late_coll;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 0;
  bit  toggle_en = 0;

  always #10 clk = ~clk;

  coll_jam_retry #(.SLOT_BITS(S)) i_coll_jam_retry (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_active(tx_active),
    .phase_preamble(phase_preamble), .bit_cnt(bit_cnt), .coll(coll), .tx_ok(tx_ok),
    .jam_active(jam_active), .jam_bit(jam_bit), .retry_req(retry_req),
    .backoff_done(backoff_done), .abort_excess(abort_excess), .late_coll(late_coll)
  );

  // {preamble cycles[7:0], bit count[15:0], expect late}
  localparam logic [24:0] VEC [0:5] = '{
    {8'd0,  16'd100,  1'b0},
    {8'd0,  16'd511,  1'b0},
    {8'd0,  16'd512,  1'b1},
    {8'd0,  16'd1500, 1'b1},
    {8'd12, 16'd0,    1'b0},
    {8'd3,  16'd700,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_ok();
    @(negedge clk); tx_ok = 1'b1;
    @(negedge clk); tx_ok = 1'b0;
  endtask

  // outcome: 0 none, 1 backoff done, 2 late, 3 abort
  task automatic do_coll(input int pre, input int bc, output int jam_n, output int ret_n,
                         output int done_n, output int outcome, output bit pviol,
                         output int first_jam);
    int pre_left = pre;
    int t = 0;
    jam_n = 0; ret_n = 0; done_n = 0; outcome = 0; pviol = 0; first_jam = -1;
    @(negedge clk);
    tx_active = 1'b1; bit_cnt = 16'(bc); phase_preamble = (pre > 0); coll = 1'b1;
    @(negedge clk);
    coll = 1'b0;
    while (t < 30000) begin
      if (jam_active && first_jam < 0) first_jam = t;
      if (jam_active && bit_en && jam_bit) jam_n++;
      if (jam_active && phase_preamble) pviol = 1;
      if (retry_req) ret_n++;
      if (backoff_done) done_n++;
      if (late_coll)    begin outcome = 2; break; end
      if (abort_excess) begin outcome = 3; break; end
      if (backoff_done) begin outcome = 1; break; end
      if (pre_left > 0) begin
        pre_left--;
        if (pre_left == 0) phase_preamble = 1'b0;
      end
      if (toggle_en) bit_en = ~bit_en;
      t++;
      @(negedge clk);
    end
    tx_active = 1'b0;
  endtask

  function automatic bit in_range(int ret, int n);
    int e = (n > 10) ? 10 : n;
    if (ret < 1 || ((ret - 1) % S) != 0) return 0;
    return ((ret - 1) / S) < (1 << e);
  endfunction

  task automatic early_run(input int n, input string req);
    int jn, rn, dn, oc, fj; bit pv;
    do_coll(0, 64, jn, rn, dn, oc, pv, fj);
    chk(oc == 1, req, oc, 1);
    chk(in_range(rn, n), "R4 backoff length", rn, n);
    chk(dn == 1, "R8 single done pulse", dn, 1);
  endtask

  initial begin
    int jn, rn, dn, oc, fj; bit pv;
    rst_n = 1'b0; bit_en = 1'b1; tx_active = 1'b0; phase_preamble = 1'b0;
    coll = 1'b0; tx_ok = 1'b0; bit_cnt = '0;
    repeat (3) @(negedge clk);
    chk({jam_active, jam_bit, retry_req, backoff_done, abort_excess, late_coll} == 6'b0,
        "R10 reset outputs", {jam_active, retry_req, backoff_done, abort_excess, late_coll}, 0);
    rst_n = 1'b1;

    // Vector table: early/late boundary and preamble holds
    for (int v = 0; v < 6; v++) begin
      int pre = int'(VEC[v][24:17]);
      int bc  = int'(VEC[v][16:1]);
      bit exp_late = VEC[v][0];
      pulse_ok();
      do_coll(pre, bc, jn, rn, dn, oc, pv, fj);
      chk(jn == J, "R1 jam length", jn, J);
      chk(pv == 0, "R2 no jam during preamble", pv, 0);
      if (pre > 0) chk(fj == pre, "R2 jam start after preamble", fj, pre);
      else         chk(fj == 0, "R1 jam starts next clock", fj, 0);
      if (exp_late) begin
        chk(oc == 2 && rn == 0, "R5 late collision", oc, 2);
      end else begin
        chk(oc == 1, "R3 retry on early collision", oc, 1);
        chk(in_range(rn, 1), "R4 first backoff range", rn, 1);
      end
    end

    // R9: collision ignored without active frame
    @(negedge clk); coll = 1'b1; tx_active = 1'b0; bit_cnt = 16'd10;
    @(negedge clk); coll = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 50; i++) begin
        if (jam_active || retry_req || late_coll || abort_excess) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R9 coll ignored when idle", seen, 0);
    end

    // R6: 15 backoffs, then abort on the 16th, then count restarts
    pulse_ok();
    for (int n = 1; n <= 15; n++) early_run(n, "R6 backoff before limit");
    do_coll(0, 64, jn, rn, dn, oc, pv, fj);
    chk(oc == 3 && rn == 0, "R6 abort on 16th collision", oc, 3);
    early_run(1, "R6 count restarts after abort");

    // R7: clear mid-run, then 15 more backoffs allowed
    pulse_ok();
    for (int n = 1; n <= 5; n++) early_run(n, "R7 pre-clear run");
    pulse_ok();
    for (int n = 1; n <= 15; n++) early_run(n, "R7 cleared count allows retries");
    do_coll(0, 64, jn, rn, dn, oc, pv, fj);
    chk(oc == 3, "R7 abort after fresh 16", oc, 3);

    // R1: jam counted in bit times with gated strobe
    toggle_en = 1'b1;
    do_coll(0, 900, jn, rn, dn, oc, pv, fj);
    toggle_en = 1'b0; bit_en = 1'b1;
    chk(jn == J, "R1 jam length with gated bit_en", jn, J);
    chk(oc == 2, "R5 late with gated bit_en", oc, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule